// File: doc/BRIEF.md
# FIFO Occupancy Interrupt Generator

This block sits beside the transmit and receive FIFOs of a serial controller and turns their occupancy into three level-sensitive interrupt requests. Each direction has its own 2-bit threshold mode. The FIFO has a fixed byte capacity, so the number of words it holds depends on the current word size. The thresholds "half" and "full" are scaled to that word depth.

Each cycle the block registers the two FIFO levels and the shifter-busy flag. It clamps the registered levels to the current word depth and decodes the interrupt lines from them. The lines are combinational from those registers and the current mode and word-size inputs. It also keeps a sticky receive-overflow flag. The flag is set when a word arrives while the receive FIFO is full. When its enable is on, the flag drives the fault interrupt. The FIFO storage is not part of the block.

Top module: `fifo_irq_gen`

## Requirements
- R1: After reset the registered levels read 0 and the overflow flag is 0. While `en_i` is 0, `tx_irq_o`, `rx_irq_o` and `fault_irq_o` are all 0.
- R2: The word depth is FIFO_BYTES divided by the word size in bytes. With the default 16 bytes this gives 16, 8 or 4 for `word_size_i` = 0 (8 bits), 1 (16 bits) or 2 (32 bits). Code 3 is reserved and acts as 8 bits.
- R3: `tx_level_o` and `rx_level_o` show the level inputs sampled at the previous rising clock edge. Each is clamped to the word depth given by the current `word_size_i`.
- R4: With `en_i` at 1, `rx_irq_o` follows `rx_mode_i` on the clamped receive level L and the depth D: 0 = L is 0, 1 = L is not 0, 2 = 2·L ≥ D, 3 = L equals D.
- R5: With `en_i` at 1, `tx_mode_i` = 0 raises `tx_irq_o` when the clamped transmit level is 0 and the registered busy flag is 0. `tx_mode_i` = 1 raises it when the level is 0, whatever the busy flag.
- R6: With `en_i` at 1, `tx_mode_i` = 2 raises `tx_irq_o` when at least half the entries are free (2·L ≤ D). `tx_mode_i` = 3 raises it when at least one entry is free (L < D).
- R7: A rising edge that sees `en_i` and `rx_push_i` at 1 while `rx_level_o` equals D sets `rx_ovf_o`. The flag stays set until an edge that sees `ovf_clr_i` at 1. When setting and clearing happen on the same edge, setting wins.
- R8: `fault_irq_o` is 1 exactly when `en_i`, `rx_ovf_o` and `ovf_irq_en_i` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable; gates all interrupt lines |
| word_size_i | input | 2 | 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = reserved (8 bits) |
| rx_mode_i | input | 2 | Receive threshold mode |
| tx_mode_i | input | 2 | Transmit threshold mode |
| tx_level_i | input | LVL_W | Transmit FIFO occupancy in words |
| rx_level_i | input | LVL_W | Receive FIFO occupancy in words |
| tx_busy_i | input | 1 | Transmit shifter holds a word |
| rx_push_i | input | 1 | A received word is being written to the FIFO |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ovf_irq_en_i | input | 1 | Enables overflow onto the fault line |
| tx_level_o | output | LVL_W | Registered, clamped transmit level |
| rx_level_o | output | LVL_W | Registered, clamped receive level |
| rx_ovf_o | output | 1 | Sticky receive-overflow flag |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |
| fault_irq_o | output | 1 | Fault interrupt request |

## Verification
The bench builds the block with the default FIFO_BYTES of 16, so LVL_W is 5. The level inputs can then reach 31, which is above the depth for every word size. This makes clamping testable in all four word-size codes, including the reserved one. The sweep covers the exact threshold points for every mode in both directions: D/2−1, D/2, D/2+1, D−1 and D. Because D is 4 at 32-bit words, an overflow appears after only a few pushes. This lets the bench hit both the same-edge set/clear case and a word-size change that makes a partly filled FIFO full.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  typedef enum logic [1:0] {WS_8 = 2'd0, WS_16 = 2'd1, WS_32 = 2'd2, WS_RSVD = 2'd3} word_size_e;
  typedef enum logic [1:0] {RX_EMPTY = 2'd0, RX_ANY = 2'd1, RX_HALF = 2'd2, RX_FULL = 2'd3} rx_mode_e;
  typedef enum logic [1:0] {TX_DRAINED = 2'd0, TX_EMPTY = 2'd1, TX_HALF = 2'd2, TX_ROOM = 2'd3} tx_mode_e;

  function automatic int unsigned elem_depth(int unsigned bytes, word_size_e ws);
    case (ws)
      WS_16:   return bytes / 2;
      WS_32:   return bytes / 4;
      default: return bytes;
    endcase
  endfunction
endpackage

// File: rtl/fifo_lvl_sat.sv
module fifo_lvl_sat #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] depth_i,
  output logic [LVL_W-1:0] lvl_o
);
  logic [LVL_W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  // clamp against depth at the current word size
  assign lvl_o = (lvl_q > depth_i) ? depth_i : lvl_q;
endmodule

// File: rtl/rx_irq_decode.sv
module rx_irq_decode
  import fifo_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  rx_mode_e         mode_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] depth_i,
  output logic             irq_o
);
  logic half_full;
  assign half_full = {lvl_i, 1'b0} >= {1'b0, depth_i};

  always_comb begin
    case (mode_i)
      RX_EMPTY: irq_o = (lvl_i == '0);
      RX_ANY:   irq_o = (lvl_i != '0);
      RX_HALF:  irq_o = half_full;
      default:  irq_o = (lvl_i == depth_i);
    endcase
  end
endmodule

// File: rtl/tx_irq_decode.sv
module tx_irq_decode
  import fifo_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  tx_mode_e         mode_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] depth_i,
  input  logic             busy_i,
  output logic             irq_o
);
  logic empty, half_free;
  assign empty     = (lvl_i == '0);
  assign half_free = {lvl_i, 1'b0} <= {1'b0, depth_i};

  always_comb begin
    case (mode_i)
      TX_DRAINED: irq_o = empty & ~busy_i;
      TX_EMPTY:   irq_o = empty;
      TX_HALF:    irq_o = half_free;
      default:    irq_o = (lvl_i < depth_i);
    endcase
  end
endmodule

// File: rtl/rx_ovf_track.sv
module rx_ovf_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ovf_o <= 1'b0;
    else if (set_i) ovf_o <= 1'b1;
    else if (clr_i) ovf_o <= 1'b0;
  end
endmodule

// File: rtl/fifo_irq_gen.sv
module fifo_irq_gen
  import fifo_irq_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 16,
  localparam int unsigned LVL_W = $clog2(FIFO_BYTES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       word_size_i,
  input  logic [1:0]       rx_mode_i,
  input  logic [1:0]       tx_mode_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             tx_busy_i,
  input  logic             rx_push_i,
  input  logic             ovf_clr_i,
  input  logic             ovf_irq_en_i,
  output logic [LVL_W-1:0] tx_level_o,
  output logic [LVL_W-1:0] rx_level_o,
  output logic             rx_ovf_o,
  output logic             tx_irq_o,
  output logic             rx_irq_o,
  output logic             fault_irq_o
);
  logic [LVL_W-1:0] depth;
  logic             busy_q, tx_raw, rx_raw, ovf_set;

  assign depth = LVL_W'(elem_depth(FIFO_BYTES, word_size_e'(word_size_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= tx_busy_i;
  end

  fifo_lvl_sat #(.LVL_W(LVL_W)) u_tx_lvl (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(tx_level_i), .depth_i(depth), .lvl_o(tx_level_o)
  );
  fifo_lvl_sat #(.LVL_W(LVL_W)) u_rx_lvl (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(rx_level_i), .depth_i(depth), .lvl_o(rx_level_o)
  );

  rx_irq_decode #(.LVL_W(LVL_W)) u_rx_dec (
    .mode_i(rx_mode_e'(rx_mode_i)), .lvl_i(rx_level_o), .depth_i(depth), .irq_o(rx_raw)
  );
  tx_irq_decode #(.LVL_W(LVL_W)) u_tx_dec (
    .mode_i(tx_mode_e'(tx_mode_i)), .lvl_i(tx_level_o), .depth_i(depth),
    .busy_i(busy_q), .irq_o(tx_raw)
  );

  assign ovf_set = en_i & rx_push_i & (rx_level_o == depth);

  rx_ovf_track u_ovf (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ovf_set), .clr_i(ovf_clr_i), .ovf_o(rx_ovf_o)
  );

  assign tx_irq_o    = en_i & tx_raw;
  assign rx_irq_o    = en_i & rx_raw;
  assign fault_irq_o = en_i & rx_ovf_o & ovf_irq_en_i;
endmodule

// File: rtl/fifo_irq_gen_chk.sv
module fifo_irq_gen_chk #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned FIFO_BYTES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       word_size_i,
  input logic [1:0]       rx_mode_i,
  input logic             rx_push_i,
  input logic             ovf_clr_i,
  input logic             ovf_irq_en_i,
  input logic [LVL_W-1:0] tx_level_o,
  input logic [LVL_W-1:0] rx_level_o,
  input logic             rx_ovf_o,
  input logic             tx_irq_o,
  input logic             rx_irq_o,
  input logic             fault_irq_o
);
  logic [LVL_W-1:0] dep;
  always_comb begin
    case (word_size_i)
      2'd1:    dep = LVL_W'(FIFO_BYTES / 2);
      2'd2:    dep = LVL_W'(FIFO_BYTES / 4);
      default: dep = LVL_W'(FIFO_BYTES);
    endcase
  end

  p_quiet_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !(tx_irq_o || rx_irq_o || fault_irq_o));
  p_lvl_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_o <= dep) && (rx_level_o <= dep));
  p_rx_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o && rx_mode_i == 2'd3) |-> rx_level_o == dep);
  p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rx_push_i && rx_level_o == dep) |=> rx_ovf_o);
  p_ovf_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovf_o && !ovf_clr_i) |=> rx_ovf_o);
  p_fault_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_irq_o |-> (rx_ovf_o && ovf_irq_en_i));
endmodule

bind fifo_irq_gen fifo_irq_gen_chk #(.LVL_W(LVL_W), .FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .word_size_i(word_size_i),
  .rx_mode_i(rx_mode_i), .rx_push_i(rx_push_i), .ovf_clr_i(ovf_clr_i),
  .ovf_irq_en_i(ovf_irq_en_i), .tx_level_o(tx_level_o), .rx_level_o(rx_level_o),
  .rx_ovf_o(rx_ovf_o), .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o), .fault_irq_o(fault_irq_o)
);

// File: tb/sim_fifo_irq_gen.sv
`timescale 1ns/1ps
module sim_fifo_irq_gen;
  localparam int LW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, busy = 0, push = 0, clr = 0, oen = 0;
  logic [1:0] ws = 0, rxm = 0, txm = 0;
  logic [LW-1:0] txl = 0, rxl = 0;
  logic [LW-1:0] tlo, rlo;
  logic ovf, tirq, rirq, firq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_tx = 0, m_rx = 0, m_busy = 0, m_ovf = 0;

  always #10 clk = ~clk;

  fifo_irq_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .word_size_i(ws), .rx_mode_i(rxm),
    .tx_mode_i(txm), .tx_level_i(txl), .rx_level_i(rxl), .tx_busy_i(busy),
    .rx_push_i(push), .ovf_clr_i(clr), .ovf_irq_en_i(oen), .tx_level_o(tlo),
    .rx_level_o(rlo), .rx_ovf_o(ovf), .tx_irq_o(tirq), .rx_irq_o(rirq), .fault_irq_o(firq)
  );

  function automatic int depth_of(int w);
    return (w == 1) ? 8 : (w == 2) ? 4 : 16;
  endfunction
  function automatic int clampi(int v, int d);
    return (v > d) ? d : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // compare at negedge, then apply new inputs and advance the model
  task automatic cyc(bit n_en, bit [1:0] n_ws, bit [1:0] n_rxm, bit [1:0] n_txm,
                     int n_txl, int n_rxl, bit n_busy, bit n_push, bit n_clr, bit n_oen);
    int d, sl, rl, e_rx, e_tx, nd;
    @(negedge clk);
    d  = depth_of(ws);
    sl = clampi(m_tx, d);
    rl = clampi(m_rx, d);
    case (rxm)
      2'd0: e_rx = (rl == 0);
      2'd1: e_rx = (rl != 0);
      2'd2: e_rx = (2 * rl >= d);
      default: e_rx = (rl == d);
    endcase
    case (txm)
      2'd0: e_tx = (sl == 0) && (m_busy == 0);
      2'd1: e_tx = (sl == 0);
      2'd2: e_tx = (2 * sl <= d);
      default: e_tx = (sl < d);
    endcase
    e_rx = en ? e_rx : 0;
    e_tx = en ? e_tx : 0;
    chk("R2,R3 tx_level", tlo, sl);
    chk("R2,R3 rx_level", rlo, rl);
    chk(!en ? "R1 rx_irq" : "R4 rx_irq", rirq, e_rx);
    chk(!en ? "R1 tx_irq" : (txm < 2 ? "R5 tx_irq" : "R6 tx_irq"), tirq, e_tx);
    chk("R7 rx_ovf", ovf, m_ovf);
    chk(!en ? "R1 fault_irq" : "R8 fault_irq", firq, (en && m_ovf && oen) ? 1 : 0);
    en = n_en; ws = n_ws; rxm = n_rxm; txm = n_txm; txl = LW'(n_txl); rxl = LW'(n_rxl);
    busy = n_busy; push = n_push; clr = n_clr; oen = n_oen;
    nd = depth_of(n_ws);
    if (n_en && n_push && clampi(m_rx, nd) == nd) m_ovf = 1;
    else if (n_clr) m_ovf = 0;
    m_tx = n_txl; m_rx = n_rxl; m_busy = n_busy;
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int pts[7];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then disabled with busy levels
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 2'(i), 2'(i), 2'(3 - i), 31, 16, 1, 0, 0, 1);
    // R2..R6: threshold sweep per word size
    for (int w = 0; w < 4; w++) begin
      int d;
      d = depth_of(w);
      pts = '{0, d / 2 - 1, d / 2, d / 2 + 1, d - 1, d, 31};
      for (int p = 0; p < 7; p++)
        for (int m = 0; m < 4; m++)
          for (int b = 0; b < 2; b++)
            cyc(1, 2'(w), 2'(m), 2'(m), pts[p], pts[6 - p], b[0], 0, 0, 0);
    end
    // R7/R8: overflow at 32-bit words
    cyc(1, 2, 3, 3, 0, 4, 0, 0, 0, 1);
    cyc(1, 2, 3, 3, 0, 4, 0, 1, 0, 1);
    cyc(1, 2, 3, 3, 0, 2, 0, 0, 0, 1);
    cyc(1, 2, 3, 3, 0, 2, 0, 0, 0, 0);
    cyc(0, 2, 3, 3, 0, 2, 0, 0, 0, 1);
    cyc(1, 2, 3, 3, 0, 4, 0, 0, 1, 1);
    cyc(1, 2, 3, 3, 0, 4, 0, 1, 1, 1);
    cyc(1, 2, 3, 3, 0, 4, 0, 1, 1, 1);
    cyc(1, 2, 3, 3, 0, 0, 0, 0, 1, 1);
    cyc(0, 2, 3, 3, 0, 31, 0, 1, 0, 1);
    cyc(0, 2, 3, 3, 0, 31, 0, 1, 0, 1);
    cyc(1, 0, 3, 3, 0, 6, 0, 0, 0, 1);
    cyc(1, 2, 3, 3, 0, 6, 0, 1, 0, 1);
    cyc(1, 2, 3, 3, 0, 6, 0, 0, 1, 1);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int w, d, tl, rl;
      w  = $urandom_range(0, 3);
      d  = depth_of(w);
      tl = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 31) : $urandom_range(0, d);
      rl = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 31) : $urandom_range(d - 1, d);
      cyc($urandom_range(0, 7) != 0, 2'(w), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
          tl, rl, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          $urandom_range(0, 9) == 0, 1'($urandom_range(0, 1)));
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule